// File: doc/BRIEF.md
# Register-Driven Packet Transmit Stager

This block lets a host processor build outgoing transaction-layer packets one 64-bit beat at a time through a small write window. The host first writes the low 32-bit word and the high 32-bit word of a beat into two holding registers. It then writes a control word whose two lowest bits flag the start and the end of a packet. That control write pushes the assembled beat and its flags into a transmit FIFO.

A streaming source drains the FIFO toward a link layer using a valid/ready handshake. A packet becomes visible downstream only once its end-of-packet beat has been written, so the link never sees a partially built packet. Starting a new packet while one is still open throws the unfinished beats away. A control write that finds the FIFO full is dropped and raises a sticky overflow flag, which the host can read back.

Register offsets (4-bit byte address): 0x0 low data word, 0x4 high data word, 0x8 control, 0xC status.

Top module: `tlp_tx_stage`

## Requirements
- R1: A write to offset 0x0 latches `reg_wr_data` as bits [31:0] of the beat pushed by the next control write.
- R2: A write to offset 0x4 latches `reg_wr_data` as bits [63:32] of the beat pushed by the next control write.
- R3: Each write to offset 0x8 pushes one beat: data {high word, low word}, SOP = `reg_wr_data[0]`, EOP = `reg_wr_data[1]`. Bits [31:2] of the control word have no effect.
- R4: `tx_valid` stays low for beats of a packet until that packet's EOP beat has been pushed.
- R5: Beats leave on `tx_valid && tx_ready` in push order with their SOP/EOP flags. While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sop` and `tx_eop` hold.
- R6: A control write while the FIFO holds DEPTH beats is dropped and sets the overflow flag. This flag is read at offset 0xC bit 0 and stays set until reset.
- R7: Reads at offsets 0x0, 0x4 and 0x8 return zero, and a read at 0xC returns {31'b0, overflow}.
- R8: A beat with SOP set, pushed while a packet is still open (no EOP yet), discards that packet's beats and starts a new packet with this beat.
- R9: Reset empties the FIFO (`tx_valid` low), clears both latched words to zero and clears the overflow flag.
- R10: The latched words keep their values after a push, so consecutive control writes without data writes repeat the same 64-bit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Committed beat available |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_sop | output | 1 | Beat starts a packet |
| tx_eop | output | 1 | Beat ends a packet |
| tx_data | output | 64 | Beat data |

## Verification
The bench builds the block with DEPTH = 4. With that depth, a four-beat packet fills the FIFO exactly, and the overflow drop is reached after only a handful of writes. Over eight table beats, the read, write and commit pointers wrap several times, which tests the modular fullness arithmetic. Directed cases then cover restarting an open packet, reserved control bits, holding under back-pressure, and a reset with a committed packet still waiting.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BEAT_W = 2 * WORD_W;

  localparam logic [REG_AW-1:0] OFF_LO   = 4'h0;
  localparam logic [REG_AW-1:0] OFF_HI   = 4'h4;
  localparam logic [REG_AW-1:0] OFF_CTL  = 4'h8;
  localparam logic [REG_AW-1:0] OFF_STAT = 4'hC;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [BEAT_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/tlp_tx_regs.sv
module tlp_tx_regs
  import tlp_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              push_drop,
  output logic              push,
  output beat_t             push_beat,
  output logic              ovf
);
  logic [WORD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              ovf_q, ovf_d;
  logic              lo_en, hi_en;

  always_comb begin
    lo_en = wr_en && (wr_addr == OFF_LO);
    hi_en = wr_en && (wr_addr == OFF_HI);
    lo_d  = lo_en ? wr_data : lo_q;
    hi_d  = hi_en ? wr_data : hi_q;
    ovf_d = ovf_q | push_drop;
    push  = wr_en && (wr_addr == OFF_CTL);
    push_beat.sop  = wr_data[0];
    push_beat.eop  = wr_data[1];
    push_beat.data = {hi_q, lo_q};
    rd_data = (rd_addr == OFF_STAT) ? {{(WORD_W-1){1'b0}}, ovf_q} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/tlp_tx_fifo.sv
module tlp_tx_fifo
  import tlp_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  beat_t push_beat,
  output logic  drop,
  output logic  out_valid,
  input  logic  out_ready,
  output beat_t out_beat
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  beat_t mem [DEPTH];

  logic [PW-1:0] wr_ptr, wr_ptr_d, cmt_ptr, cmt_ptr_d, rd_ptr, rd_ptr_d;
  logic [PW-1:0] base;
  logic          open_pkt, restart, full, accept, pop;

  always_comb begin
    open_pkt  = (wr_ptr != cmt_ptr);
    restart   = push && push_beat.sop && open_pkt;
    base      = restart ? cmt_ptr : wr_ptr;
    full      = ((base - rd_ptr) == DEPTH_P);
    accept    = push && !full;
    drop      = push && full;
    wr_ptr_d  = accept ? base + 1'b1 : wr_ptr;
    cmt_ptr_d = (accept && push_beat.eop) ? base + 1'b1 : cmt_ptr;
    out_valid = (rd_ptr != cmt_ptr);
    pop       = out_valid && out_ready;
    rd_ptr_d  = pop ? rd_ptr + 1'b1 : rd_ptr;
    out_beat  = mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      wr_ptr  <= wr_ptr_d;
      cmt_ptr <= cmt_ptr_d;
      rd_ptr  <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[base[AW-1:0]] <= push_beat;
  end
endmodule

// File: rtl/tlp_tx_stage.sv
module tlp_tx_stage
  import tlp_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [WORD_W-1:0] reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [WORD_W-1:0] reg_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [BEAT_W-1:0] tx_data
);
  logic  rst_meta, rst_int_n;
  logic  push, push_drop, ovf_flag;
  beat_t push_beat, out_beat;

  // reset asserts at once, deasserts two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  tlp_tx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_addr   (reg_rd_addr),
    .rd_data   (reg_rd_data),
    .push_drop (push_drop),
    .push      (push),
    .push_beat (push_beat),
    .ovf       (ovf_flag)
  );

  tlp_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .push_beat (push_beat),
    .drop      (push_drop),
    .out_valid (tx_valid),
    .out_ready (tx_ready),
    .out_beat  (out_beat)
  );

  assign tx_sop  = out_beat.sop;
  assign tx_eop  = out_beat.eop;
  assign tx_data = out_beat.data;
endmodule

// File: rtl/tlp_tx_chk.sv
module tlp_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eop_wr,
  input logic [3:0]  reg_rd_addr,
  input logic [31:0] reg_rd_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic [63:0] tx_data,
  input logic        push_drop,
  input logic        ovf
);
  logic [7:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + 8'(eop_wr && !push_drop) - 8'(tx_valid && tx_ready && tx_eop);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !tx_valid); // R9
  AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend != 8'd0); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)); // R5
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R6
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_addr != 4'hC |-> reg_rd_data == 32'h0); // R7
endmodule

bind tlp_tx_stage tlp_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eop_wr      (reg_wr_en && (reg_wr_addr == 4'h8) && reg_wr_data[1]),
  .reg_rd_addr (reg_rd_addr),
  .reg_rd_data (reg_rd_data),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_sop      (tx_sop),
  .tx_eop      (tx_eop),
  .tx_data     (tx_data),
  .push_drop   (push_drop),
  .ovf         (ovf_flag)
);

// File: tb/tlp_tx_stage_tb.sv
module tlp_tx_stage_tb_top;
  localparam int DEPTH = 4;
  localparam int NVEC  = 8;
  // {ctl[1:0], hi, lo}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd3, 32'hA000_0001, 32'h0000_0011},
    {2'd1, 32'hB000_0001, 32'h0000_0021},
    {2'd0, 32'hB000_0002, 32'h0000_0022},
    {2'd2, 32'hB000_0003, 32'h0000_0023},
    {2'd1, 32'hC000_0001, 32'h0000_0031},
    {2'd0, 32'hC000_0002, 32'h0000_0032},
    {2'd0, 32'hC000_0003, 32'h0000_0033},
    {2'd2, 32'hC000_0004, 32'h0000_0034}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        tx_valid, tx_sop, tx_eop;
  logic        tx_ready = 1'b0;
  logic [63:0] tx_data;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  tlp_tx_stage #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic push_beat(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] ctl);
    reg_wr(4'h0, lo);
    reg_wr(4'h4, hi);
    reg_wr(4'h8, ctl);
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_rd_addr = a;
    #1;
    chk(reg_rd_data == exp, req, "read data", {34'b0, reg_rd_data}, {34'b0, exp});
  endtask

  // check beat at current negedge, then pop it
  task automatic take(input bit s, input bit e, input logic [63:0] d, input string req);
    chk(tx_valid && tx_sop == s && tx_eop == e && tx_data == d, req, "beat",
        {tx_sop, tx_eop, tx_data}, {s, e, d});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic chk_empty(input string req);
    chk(!tx_valid, req, "tx_valid low", {65'b0, tx_valid}, 66'b0);
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int first;
    do_reset();
    // R9 reset state
    chk_empty("R9");
    reg_rd(4'hC, 32'h0, "R9");

    // table walk: R1 R2 R3 R4 R5
    first = 0;
    for (int i = 0; i < NVEC; i++) begin
      push_beat(VEC[i][31:0], VEC[i][63:32], {30'b0, VEC[i][65:64]});
      chk(tx_valid == VEC[i][65], "R4", "valid after push", {65'b0, tx_valid}, {65'b0, VEC[i][65]});
      if (VEC[i][65]) begin
        for (int k = first; k <= i; k++)
          take(VEC[k][64], VEC[k][65], VEC[k][63:0], "R5");
        chk_empty("R5");
        first = i + 1;
      end
    end

    // R7 write-only registers read zero
    reg_wr(4'h0, 32'hDEAD_BEEF);
    reg_wr(4'h4, 32'h1234_5678);
    reg_rd(4'h0, 32'h0, "R7");
    reg_rd(4'h4, 32'h0, "R7");
    reg_rd(4'h8, 32'h0, "R7");
    reg_rd(4'hC, 32'h0, "R7");

    // R3 reserved control bits ignored
    reg_wr(4'h8, 32'hFFFF_FFF3);
    take(1'b1, 1'b1, 64'h1234_5678_DEAD_BEEF, "R3");
    chk_empty("R3");

    // R10 words persist across pushes; R1 R2 placement
    reg_wr(4'h8, 32'h1);
    reg_wr(4'h8, 32'h2);
    take(1'b1, 1'b0, 64'h1234_5678_DEAD_BEEF, "R10");
    take(1'b0, 1'b1, 64'h1234_5678_DEAD_BEEF, "R10");

    // R8 SOP while open discards the open packet
    push_beat(32'h1, 32'h7, 32'h1);
    push_beat(32'h2, 32'h7, 32'h0);
    chk_empty("R8");
    push_beat(32'h3, 32'h7, 32'h1);
    push_beat(32'h4, 32'h7, 32'h2);
    take(1'b1, 1'b0, 64'h0000_0007_0000_0003, "R8");
    take(1'b0, 1'b1, 64'h0000_0007_0000_0004, "R8");
    chk_empty("R8");

    // R5 hold under back-pressure
    push_beat(32'h55, 32'h66, 32'h3);
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_data == 64'h66_0000_0055, "R5", "held beat",
        {tx_sop, tx_eop, tx_data}, {2'b11, 64'h66_0000_0055});
    take(1'b1, 1'b1, 64'h66_0000_0055, "R5");

    // R6 overflow: fill DEPTH beats, next push dropped
    for (int k = 0; k < DEPTH; k++)
      push_beat(32'h40 + k, 32'h9, {30'b0, (k == DEPTH-1), (k == 0)});
    reg_rd(4'hC, 32'h0, "R6");
    push_beat(32'h99, 32'h9, 32'h3);
    reg_rd(4'hC, 32'h1, "R6");
    for (int k = 0; k < DEPTH; k++)
      take(k == 0, k == DEPTH-1, {32'h9, 32'h40 + k}, "R6");
    chk_empty("R6");
    reg_rd(4'hC, 32'h1, "R6");

    // R9 reset with a committed packet pending
    push_beat(32'hAB, 32'hCD, 32'h3);
    do_reset();
    chk_empty("R9");
    reg_rd(4'hC, 32'h0, "R9");
    reg_wr(4'h8, 32'h3);
    take(1'b1, 1'b1, 64'h0, "R9");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule